// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable ROM with Identification Mode

This block is a clocked, synthesizable model of a byte-wide read-only memory device as seen from its pins. A host drives an address, two active-low enables (chip select and output gate), a flag that marks the programming supply as raised, and a flag that marks the high-voltage level on address line 9. The block answers with an 8-bit data bus and a matching drive-enable. When the bus is not driven, the data bus is high impedance. The full-size device is 32768 bytes with 15 address lines (`ADDR_W = 15`). The default configuration is smaller so that it elaborates cheaply.

Programming follows one-time-programmable cell behaviour: a write pulse can only clear bits that are still 1. The `PULSES` parameter sets how many consecutive pulses one byte needs before it takes its value, which lets a retry-based programmer be exercised. Read data appears only after the address and controls have held steady for `ACC_CYCLES` sampled clock edges. The bus floats one edge after either enable goes high. An identification mode returns a fixed manufacturer or device byte in place of array data.

Top module: `otp_rom_ident`

## Requirements
- R1: While `rst_ni` is low and after it is released, `data_oe_o` is low and every location is reloaded. With `INIT_MODE=1`, location a holds (a mod 256) XOR 0xA5. With `INIT_MODE=0`, every location holds 0xFF.
- R2: With `ce_ni`=0 and `oe_ni`=0, `data_oe_o` goes high after the edge on which `addr_i`, `ce_ni`, `oe_ni`, `a9_hv_i` and `vpp_hi_i` have been sampled unchanged for `ACC_CYCLES` consecutive edges. `data_o` then carries the byte selected from those inputs.
- R3: A `ce_ni`=1 sampled on an edge leaves `data_oe_o` low after that edge, whatever `oe_ni` is (standby).
- R4: With `ce_ni`=0, an `oe_ni`=1 sampled on an edge leaves `data_oe_o` low after that edge (output disable).
- R5: Any change in the address or in a control input restarts the settle count, so `data_oe_o` stays low for the next `ACC_CYCLES-1` edges.
- R6: Identification mode applies when `a9_hv_i`=1, `vpp_hi_i`=0, and every address bit other than bit 0 and bit 9 is 0. A read in this mode returns 0x1E when address bit 0 is 0 and 0x8C when it is 1.
- R7: With `a9_hv_i`=1 and any address bit other than bits 0 and 9 set, a read returns array data.
- R8: A program write happens on entry into the condition `vpp_hi_i`=1, `ce_ni`=0, `oe_ni`=1. It stores old AND `din_i`, so a 0 bit can never return to 1.
- R9: A byte commits only after `PULSES` consecutive entries into the write condition with the same address and data. A pulse aimed at a different address or data restarts the count at one.
- R10: With `vpp_hi_i`=1, `ce_ni`=0 and `oe_ni`=0 (program verify), the stored array byte is driven after the settle count, and identification mode does not apply.
- R11: With `vpp_hi_i`=1 and `ce_ni`=1 (program inhibit), no location changes and the bus floats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; reloads the array |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output gate, active low |
| addr_i | input | ADDR_W | Byte address |
| a9_hv_i | input | 1 | High-voltage level present on address line 9 |
| vpp_hi_i | input | 1 | Programming supply raised |
| din_i | input | 8 | Byte to program |
| data_o | output | 8 | Data bus, high impedance when not driven |
| data_oe_o | output | 1 | High while `data_o` is driven |

## Verification
The hardest state to reach is a byte that has received fewer than `PULSES` pulses, and a pulse count that has been broken by a pulse to another target. Neither state is visible until a verify read happens to land on that byte. The bench builds `PULSES=2` and interleaves single pulses to two neighbouring addresses with verify reads. This shows that a lone pulse leaves the byte unchanged and that a switch of target restarts the count. The bench also tries to set cleared bits back to 1 and to write under program inhibit, and each attempt is followed by a verify read of the affected byte.

// File: rtl/otp_rom_pkg.sv
package otp_rom_pkg;

  localparam logic [7:0] MFR_CODE   = 8'h1E;
  localparam logic [7:0] DEV_CODE   = 8'h8C;
  localparam int         ID_HV_BIT  = 9;
  localparam int         ID_SEL_BIT = 0;
  localparam logic [7:0] PAT_XOR    = 8'hA5;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_DISABLE,
    MODE_READ,
    MODE_IDENT,
    MODE_PROGRAM,
    MODE_VERIFY,
    MODE_INHIBIT
  } rom_mode_e;

  function automatic logic [7:0] init_byte(input int mode, input int unsigned a);
    logic [7:0] lo;
    lo = a[7:0];
    if (mode == 0) return 8'hFF;
    return lo ^ PAT_XOR;
  endfunction

endpackage

// File: rtl/rom_mode_decode.sv
module rom_mode_decode
  import otp_rom_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              vpp_hi_i,
  input  logic              a9_hv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              drive_o,
  output logic              prog_o,
  output logic              id_hit_o,
  output logic [7:0]        id_byte_o
);

  localparam logic [ADDR_W-1:0] ONE     = 1;
  localparam logic [ADDR_W-1:0] ID_FREE = (ONE << ID_SEL_BIT) | (ONE << ID_HV_BIT);

  rom_mode_e mode;
  logic      id_addr_ok;

  assign id_addr_ok = ((addr_i & ~ID_FREE) == '0);

  always_comb begin
    if (ce_ni)                        mode = vpp_hi_i ? MODE_INHIBIT : MODE_STANDBY;
    else if (vpp_hi_i)                mode = oe_ni ? MODE_PROGRAM : MODE_VERIFY;
    else if (oe_ni)                   mode = MODE_DISABLE;
    else if (a9_hv_i && id_addr_ok)   mode = MODE_IDENT;
    else                              mode = MODE_READ;
  end

  assign drive_o   = (mode == MODE_READ) || (mode == MODE_IDENT) || (mode == MODE_VERIFY);
  assign prog_o    = (mode == MODE_PROGRAM);
  assign id_hit_o  = (mode == MODE_IDENT);
  assign id_byte_o = addr_i[ID_SEL_BIT] ? DEV_CODE : MFR_CODE;

endmodule

// File: rtl/rom_settle_timer.sv
module rom_settle_timer #(
  parameter int ACC_CYCLES = 3,
  parameter int KEY_W      = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [KEY_W-1:0] key_i,
  output logic             ready_o
);

  localparam int CW = $clog2(ACC_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(ACC_CYCLES);

  logic [KEY_W-1:0] key_q;
  logic [CW-1:0]    run_q, run_d;

  always_comb begin
    if (key_i == key_q && run_q != '0)
      run_d = (run_q == LIMIT) ? LIMIT : run_q + 1'b1;
    else
      run_d = CW'(1);
  end

  assign ready_o = (run_d >= LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      run_q <= '0;
    end else begin
      key_q <= key_i;
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/rom_otp_array.sv
module rom_otp_array
  import otp_rom_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PULSES    = 1,
  parameter int INIT_MODE = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        din_i,
  output logic [7:0]        rd_data_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];
  logic       prog_q;
  logic       entry;
  logic       commit;

  assign entry = prog_i && !prog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prog_q <= 1'b0;
    else         prog_q <= prog_i;
  end

  generate
    if (PULSES <= 1) begin : g_single
      assign commit = entry;
    end else begin : g_retry
      localparam int PW = $clog2(PULSES + 1);
      localparam logic [PW-1:0] NEED = PW'(PULSES);
      logic [PW-1:0]     cnt_q, cnt_n;
      logic [ADDR_W-1:0] tgt_addr_q;
      logic [7:0]        tgt_data_q;
      logic              same;

      assign same   = (cnt_q != '0) && (tgt_addr_q == addr_i) && (tgt_data_q == din_i);
      assign cnt_n  = same ? cnt_q + 1'b1 : PW'(1);
      assign commit = entry && (cnt_n >= NEED);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q      <= '0;
          tgt_addr_q <= '0;
          tgt_data_q <= '0;
        end else if (entry) begin
          tgt_addr_q <= addr_i;
          tgt_data_q <= din_i;
          cnt_q      <= commit ? '0 : cnt_n;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_byte(INIT_MODE, i);
    end else if (commit) begin
      mem[addr_i] <= mem[addr_i] & din_i;  // cells only discharge
    end
  end

  assign rd_data_o = mem[addr_i];

endmodule

// File: rtl/otp_rom_ident.sv
module otp_rom_ident
  import otp_rom_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int ACC_CYCLES = 3,
  parameter int PULSES     = 1,
  parameter int INIT_MODE  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              a9_hv_i,
  input  logic              vpp_hi_i,
  input  logic [7:0]        din_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o
);

  localparam int KEY_W = ADDR_W + 4;

  logic             drive, prog, id_hit, ready;
  logic [7:0]       id_byte, rd_data, data_q;
  logic             oe_q;
  logic [KEY_W-1:0] key;

  assign key = {addr_i, a9_hv_i, vpp_hi_i, ce_ni, oe_ni};

  rom_mode_decode #(.ADDR_W(ADDR_W)) u_dec (
    .ce_ni     (ce_ni),
    .oe_ni     (oe_ni),
    .vpp_hi_i  (vpp_hi_i),
    .a9_hv_i   (a9_hv_i),
    .addr_i    (addr_i),
    .drive_o   (drive),
    .prog_o    (prog),
    .id_hit_o  (id_hit),
    .id_byte_o (id_byte)
  );

  rom_settle_timer #(.ACC_CYCLES(ACC_CYCLES), .KEY_W(KEY_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .key_i   (key),
    .ready_o (ready)
  );

  rom_otp_array #(.ADDR_W(ADDR_W), .PULSES(PULSES), .INIT_MODE(INIT_MODE)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .prog_i    (prog),
    .addr_i    (addr_i),
    .din_i     (din_i),
    .rd_data_o (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q   <= 1'b0;
      data_q <= '0;
    end else begin
      oe_q   <= drive && ready;
      data_q <= id_hit ? id_byte : rd_data;
    end
  end

  assign data_oe_o = oe_q;
  assign data_o    = oe_q ? data_q : 8'bz;

endmodule

// File: rtl/otp_rom_chk.sv
module otp_rom_chk
  import otp_rom_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              a9_hv_i,
  input logic              vpp_hi_i,
  input logic [7:0]        din_i,
  input logic [7:0]        data_o,
  input logic              data_oe_o
);

  logic id_in;
  assign id_in = a9_hv_i && !vpp_hi_i && (addr_i[ADDR_W-1:1] & ~(1 << (ID_HV_BIT - 1))) == '0;

  // R3
  standby_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> !data_oe_o);

  // R4
  out_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && oe_ni) |=> !data_oe_o);

  // R11
  inhibit_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vpp_hi_i && ce_ni) |=> !data_oe_o);

  // R2
  drive_needs_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_oe_o) |-> $past(!ce_ni && !oe_ni));

  // R6
  ident_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && id_in) |=>
      (!data_oe_o || data_o == ($past(addr_i[ID_SEL_BIT]) ? DEV_CODE : MFR_CODE)));

endmodule

bind otp_rom_ident otp_rom_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/otp_rom_ident_bench.sv
module otp_rom_ident_bench;

  localparam int AW  = 11;
  localparam int ACC = 3;
  localparam int NP  = 2;

  logic          clk = 0;
  logic          rst_ni = 0;
  logic          ce_ni = 1, oe_ni = 1, a9_hv_i = 0, vpp_hi_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    din_i = 8'hFF;
  logic [7:0]    data_o;
  logic          data_oe_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  otp_rom_ident #(.ADDR_W(AW), .ACC_CYCLES(ACC), .PULSES(NP), .INIT_MODE(1)) u_otp_rom_ident (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni), .addr_i(addr_i),
    .a9_hv_i(a9_hv_i), .vpp_hi_i(vpp_hi_i), .din_i(din_i),
    .data_o(data_o), .data_oe_o(data_oe_o));

  // behavioural reference model
  byte unsigned model_mem [int];
  int  run = 0;
  logic [AW+3:0] last_key;
  bit  prev_prog = 0;
  int  pcount = 0;
  int  tgt_a = -1, tgt_d = -1;
  bit  exp_en = 0;
  byte unsigned exp_data = 0;

  function automatic byte unsigned stored(int a);
    if (model_mem.exists(a)) return model_mem[a];
    return byte'((a % 256) ^ 8'hA5);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      model_mem.delete();
      run = 0; prev_prog = 0; pcount = 0; tgt_a = -1; tgt_d = -1;
      exp_en = 0; exp_data = 0;
    end else begin
      logic [AW+3:0] k;
      bit id, prog;
      k = {addr_i, a9_hv_i, vpp_hi_i, ce_ni, oe_ni};
      if (run > 0 && k == last_key) run++; else run = 1;
      last_key = k;
      id = a9_hv_i && !vpp_hi_i && ((int'(addr_i) & ~32'h201) == 0);
      exp_en = !ce_ni && !oe_ni && run >= ACC;
      exp_data = id ? (addr_i[0] ? 8'h8C : 8'h1E) : stored(int'(addr_i));
      prog = !ce_ni && oe_ni && vpp_hi_i;
      if (prog && !prev_prog) begin
        if (pcount > 0 && tgt_a == int'(addr_i) && tgt_d == int'(din_i)) pcount++;
        else pcount = 1;
        tgt_a = int'(addr_i); tgt_d = int'(din_i);
        if (pcount >= NP) begin
          model_mem[int'(addr_i)] = stored(int'(addr_i)) & din_i;
          pcount = 0;
        end
      end
      prev_prog = prog;
    end
  end

  string phase = "R1";

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      checks++;
      if (data_oe_o !== exp_en || (exp_en && data_o !== exp_data)) begin
        fails++;
        $display("FAIL %s model: en=%b/%b data=%h/%h (act/exp)", phase,
                 data_oe_o, exp_en, data_o, exp_data);
      end
    end
  end

  task automatic chk(string tag, logic en_exp, logic [7:0] d_exp, bit cmp_d);
    checks++;
    if (data_oe_o !== en_exp || (cmp_d && data_o !== d_exp)) begin
      fails++;
      $display("FAIL %s: en=%b exp %b, data=%h exp %h", tag, data_oe_o, en_exp, data_o, d_exp);
    end
  endtask

  task automatic drive(logic ce, logic oe, logic [AW-1:0] a, logic hv, logic vpp, logic [7:0] d);
    ce_ni = ce; oe_ni = oe; addr_i = a; a9_hv_i = hv; vpp_hi_i = vpp; din_i = d;
  endtask

  // drive a read at negedge, check settle boundary then data
  task automatic read_chk(string tag, logic [AW-1:0] a, logic hv, logic vpp, logic [7:0] expd);
    @(negedge clk);
    drive(0, 0, a, hv, vpp, 8'hFF);
    repeat (ACC - 1) @(negedge clk);
    chk({tag, "/R5 settle"}, 1'b0, 8'h00, 0);
    @(negedge clk);
    chk(tag, 1'b1, expd, 1);
  endtask

  task automatic pulse(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    drive(0, 1, a, 0, 1, d);
    repeat (2) @(negedge clk);
    drive(1, 1, a, 0, 1, d);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset float", 1'b0, 8'h00, 0);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 after release", 1'b0, 8'h00, 0);

    phase = "R2";
    read_chk("R1/R2 read 0x005", 11'h005, 0, 0, 8'h05 ^ 8'hA5);
    read_chk("R2 read 0x7FF", 11'h7FF, 0, 0, 8'hFF ^ 8'hA5);
    @(negedge clk); drive(0, 0, 11'h006, 0, 0, 8'hFF);
    @(negedge clk);
    chk("R5 addr change floats", 1'b0, 8'h00, 0);
    repeat (2) @(negedge clk);
    chk("R5 addr change settles", 1'b1, 8'h06 ^ 8'hA5, 1);

    phase = "R4";
    @(negedge clk); drive(0, 1, 11'h006, 0, 0, 8'hFF);
    @(negedge clk); chk("R4 output disable", 1'b0, 8'h00, 0);
    phase = "R3";
    read_chk("R3 pre-read", 11'h010, 0, 0, 8'h10 ^ 8'hA5);
    @(negedge clk); drive(1, 0, 11'h010, 0, 0, 8'hFF);
    @(negedge clk); chk("R3 standby oe low", 1'b0, 8'h00, 0);
    repeat (4) @(negedge clk); chk("R3 standby held", 1'b0, 8'h00, 0);

    phase = "R6";
    read_chk("R6 manufacturer", 11'h000, 1, 0, 8'h1E);
    read_chk("R6 device", 11'h001, 1, 0, 8'h8C);
    read_chk("R6 bit9 set", 11'h201, 1, 0, 8'h8C);
    phase = "R7";
    read_chk("R7 other bit set", 11'h208, 1, 0, 8'h08 ^ 8'hA5);

    phase = "R9";
    pulse(11'h040, 8'h0F);
    read_chk("R9 one pulse no commit", 11'h040, 0, 1, 8'h40 ^ 8'hA5);
    pulse(11'h040, 8'h0F);
    phase = "R8";
    read_chk("R8/R10 verify committed", 11'h040, 0, 1, (8'h40 ^ 8'hA5) & 8'h0F);
    pulse(11'h040, 8'hFF); pulse(11'h040, 8'hFF);
    read_chk("R8 no set back", 11'h040, 0, 0, (8'h40 ^ 8'hA5) & 8'h0F);
    phase = "R10";
    read_chk("R10 verify ignores id", 11'h001, 1, 1, 8'h01 ^ 8'hA5);

    phase = "R11";
    @(negedge clk); drive(1, 1, 11'h040, 0, 1, 8'h00);
    @(negedge clk); chk("R11 inhibit float", 1'b0, 8'h00, 0);
    @(negedge clk); drive(1, 0, 11'h040, 0, 1, 8'h00);
    repeat (3) @(negedge clk);
    read_chk("R11 inhibit no write", 11'h040, 0, 1, (8'h40 ^ 8'hA5) & 8'h0F);

    phase = "R9";
    pulse(11'h041, 8'h00);
    pulse(11'h042, 8'h00);
    pulse(11'h041, 8'h00);
    read_chk("R9 target switch restarts", 11'h041, 0, 1, 8'h41 ^ 8'hA5);
    pulse(11'h041, 8'h00);
    read_chk("R9 second pulse commits", 11'h041, 0, 1, 8'h00);

    phase = "R1";
    @(negedge clk); rst_ni = 0; drive(1, 1, '0, 0, 0, 8'hFF);
    @(negedge clk); rst_ni = 1;
    read_chk("R1 reset reloads", 11'h041, 0, 0, 8'h41 ^ 8'hA5);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, act hung exp done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule